// File: doc/BRIEF.md
# Multi-Lane Link Self-Test Pattern Engine

This block adds an at-speed self-test to a multi-lane serial link. Its transmit half sits in front of the per-lane line encoder. When the test request is high and the transmit clock is reported good, it discards the parallel payload and drives a free-running PRBS-7 word onto every lane instead. The encoder still sees an ordinary word stream, so DC balancing and line coding stay in the path. When test mode is off, the transmit half is a plain pass-through stream stage.

The receive half sits after the per-lane decoders. There is no control pin: it watches the decoded words and predicts every bit from the bits already received. Once lock is reported and a long enough run of words matches the prediction on all lanes, it declares test mode by itself. It then turns its parallel output into per-lane status fields, each holding a saturating error count and a pass flag. It returns to the normal data path after a long run of words that fail on every lane, or at once when lock is lost.

Both halves run on one clock. The transmit half is valid/ready on both sides. When test mode is off, `tx_s_ready` follows `tx_m_ready`. When test mode is on, the payload input is always ready and its words are dropped, and the pattern output always offers a word and advances only on a handshake. The receive side has no ready signal, because a recovered link cannot be stalled. Each lane is `W` bits wide, and lane `l` occupies bits `[l*W +: W]` of every bus.

Top module: `lane_bist`

## Requirements
- R1: The transmit half is in test mode only while `tx_test_en` and `tx_clk_ok` are both high. Otherwise `tx_m_data`=`tx_s_data`, `tx_m_valid`=`tx_s_valid` and `tx_s_ready`=`tx_m_ready`.
- R2: In transmit test mode `tx_s_ready` and `tx_m_valid` are 1 and `tx_s_data` is ignored. Lane `l` carries PRBS-7 (x^7+x^6+1) from a 7-bit state whose reset value is l+1. Each new bit is state[6]^state[5] and is shifted into state[0]. A word holds `W` successive bits, the earliest at the MSB.
- R3: The transmit sequence advances by one word only on a clock edge where `tx_m_ready` is high in test mode. While `tx_m_ready` is low the offered word is held.
- R4: The receive half never enters test mode while `rx_lock` is low. A low `rx_lock` leaves test mode at the next edge, and that word appears raw on the output.
- R5: Each received bit is predicted as the XOR of the bits received 6 and 7 positions earlier in the same lane's stream, MSB of each word first. A single flipped bit therefore causes exactly 3 mispredictions.
- R6: Test mode is entered on the 32nd consecutive valid word, with `rx_lock` high, in which every lane has no misprediction. The status output already applies to that 32nd word.
- R7: In test mode, field `l` of `rx_o_data` holds lane l's error count in bits [7:0] and its pass flag in bit 8, with zeros above. All error counts clear on entry.
- R8: Each valid word in test mode adds its number of mispredicted bits to the lane count, which saturates at 255.
- R9: A lane's pass flag is 1 exactly while its error count is 0.
- R10: Test mode is left on the 64th consecutive valid word in which every lane has at least one misprediction. That word appears raw.
- R11: `rx_o_valid` is `rx_valid` delayed by one edge. Outside test mode `rx_o_data` is `rx_data` delayed by one edge.
- R12: A lane word of all zeros never counts as clean, so an idle all-zero stream never enters test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_test_en | input | 1 | Self-test request, transmit side |
| tx_clk_ok | input | 1 | Transmit clock reported good |
| tx_s_valid | input | 1 | Payload word valid |
| tx_s_ready | output | 1 | Payload word accepted |
| tx_s_data | input | LANES*W | Payload, all lanes |
| tx_m_valid | output | 1 | Word offered to the encoders |
| tx_m_ready | input | 1 | Encoders accept the word |
| tx_m_data | output | LANES*W | Word to the encoders, all lanes |
| rx_lock | input | 1 | Receiver lock on all lanes |
| rx_valid | input | 1 | Decoded word valid |
| rx_data | input | LANES*W | Decoded words, all lanes |
| rx_o_valid | output | 1 | Output word valid |
| rx_o_data | output | LANES*W | Raw data or per-lane status fields |
| rx_bist_active | output | 1 | Receive half is in test mode |

## Verification
The transmit results are combinational and are checked in the same cycle the inputs are driven. The sequence steps at the following edge, so a held word is checked again one cycle later. Every receive result arrives one edge after the word that causes it: mode, counts and raw data all register at that edge. The bench drives each receive word at a falling edge and reads the outputs at the next falling edge. Its word counts for entry (32) and exit (64) are sampled on the exact word and the word before.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int PRBS_LEN = 7;
  localparam int CNT_W    = 8;
  localparam int PASS_BIT = CNT_W;

  typedef logic [PRBS_LEN-1:0] prbs_t;
  typedef logic [CNT_W-1:0]    ecnt_t;

  function automatic prbs_t lane_seed(int unsigned lane);
    return prbs_t'((lane % 127) + 1);
  endfunction
endpackage

// File: rtl/prbs_gen_lane.sv
module prbs_gen_lane
  import lbist_pkg::*;
#(
  parameter int    W    = 16,
  parameter prbs_t SEED = 7'd1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] word
);
  prbs_t st, st_nxt, s;
  logic  nb;

  always_comb begin
    s    = st;
    nb   = 1'b0;
    word = '0;
    for (int i = W - 1; i >= 0; i--) begin
      nb      = s[6] ^ s[5];
      word[i] = nb;
      s       = {s[5:0], nb};
    end
    st_nxt = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= SEED;
    else if (adv) st <= st_nxt;
  end
endmodule

// File: rtl/prbs_chk_lane.sv
module prbs_chk_lane
  import lbist_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [W-1:0] word,
  input  logic         cnt_clr,
  input  logic         cnt_en,
  output logic         clean,
  output logic         miss,
  output ecnt_t        cnt_nxt
);
  localparam int NW = $clog2(W + 1);
  localparam int SW = CNT_W + 1;

  prbs_t          hist, hist_nxt, h;
  ecnt_t          cnt;
  logic [NW-1:0]  nmiss;
  logic [SW-1:0]  sum;
  logic           pred;

  always_comb begin
    h     = hist;
    nmiss = '0;
    pred  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      pred  = h[6] ^ h[5];
      nmiss = nmiss + NW'(pred ^ word[i]);
      h     = {h[5:0], word[i]};
    end
    hist_nxt = h;
  end

  assign clean = (nmiss == '0) && (word != '0);
  assign miss  = (nmiss != '0);
  assign sum   = {1'b0, cnt} + SW'(nmiss);

  always_comb begin
    if (cnt_clr)               cnt_nxt = '0;
    else if (cnt_en && valid)  cnt_nxt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    else                       cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
    end else begin
      if (valid) hist <= hist_nxt;
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rx_mode_ctl.sv
module rx_mode_ctl #(
  parameter int ENTER_RUN = 32,
  parameter int EXIT_RUN  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic lock,
  input  logic all_clean,
  input  logic all_miss,
  output logic mode,
  output logic mode_nxt,
  output logic enter
);
  localparam int CW = $clog2(ENTER_RUN);
  localparam int MW = $clog2(EXIT_RUN);

  logic [CW-1:0] clean_run, clean_nxt;
  logic [MW-1:0] miss_run, miss_nxt;

  always_comb begin
    mode_nxt  = mode;
    clean_nxt = clean_run;
    miss_nxt  = miss_run;
    enter     = 1'b0;
    if (!lock) begin
      mode_nxt  = 1'b0;
      clean_nxt = '0;
      miss_nxt  = '0;
    end else if (valid) begin
      if (!mode) begin
        miss_nxt = '0;
        if (!all_clean) begin
          clean_nxt = '0;
        end else if (clean_run == CW'(ENTER_RUN - 1)) begin
          mode_nxt  = 1'b1;
          enter     = 1'b1;
          clean_nxt = '0;
        end else begin
          clean_nxt = clean_run + 1'b1;
        end
      end else begin
        clean_nxt = '0;
        if (!all_miss) begin
          miss_nxt = '0;
        end else if (miss_run == MW'(EXIT_RUN - 1)) begin
          mode_nxt = 1'b0;
          miss_nxt = '0;
        end else begin
          miss_nxt = miss_run + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= 1'b0;
      clean_run <= '0;
      miss_run  <= '0;
    end else begin
      mode      <= mode_nxt;
      clean_run <= clean_nxt;
      miss_run  <= miss_nxt;
    end
  end
endmodule

// File: rtl/lane_bist.sv
module lane_bist
  import lbist_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int W         = 16,
  parameter int ENTER_RUN = 32,
  parameter int EXIT_RUN  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_test_en,
  input  logic               tx_clk_ok,
  input  logic               tx_s_valid,
  output logic               tx_s_ready,
  input  logic [LANES*W-1:0] tx_s_data,
  output logic               tx_m_valid,
  input  logic               tx_m_ready,
  output logic [LANES*W-1:0] tx_m_data,
  input  logic               rx_lock,
  input  logic               rx_valid,
  input  logic [LANES*W-1:0] rx_data,
  output logic               rx_o_valid,
  output logic [LANES*W-1:0] rx_o_data,
  output logic               rx_bist_active
);
  localparam int BW = LANES * W;

  logic          tx_act;
  logic [BW-1:0] pat;
  logic [LANES-1:0] clean_v, miss_v;
  ecnt_t         cnt_v [LANES];
  logic          mode, mode_nxt, enter;
  logic [BW-1:0] o_nxt;

  // transmit half
  assign tx_act     = tx_test_en & tx_clk_ok;
  assign tx_m_valid = tx_act | tx_s_valid;
  assign tx_s_ready = tx_act | tx_m_ready;
  assign tx_m_data  = tx_act ? pat : tx_s_data;

  for (genvar l = 0; l < LANES; l++) begin : g_tx
    prbs_gen_lane #(.W(W), .SEED(lane_seed(l))) u_gen (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (tx_act & tx_m_ready),
      .word (pat[l*W +: W])
    );
  end

  // receive half
  for (genvar l = 0; l < LANES; l++) begin : g_rx
    prbs_chk_lane #(.W(W)) u_chk (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (rx_valid),
      .word   (rx_data[l*W +: W]),
      .cnt_clr(enter),
      .cnt_en (mode & rx_lock),
      .clean  (clean_v[l]),
      .miss   (miss_v[l]),
      .cnt_nxt(cnt_v[l])
    );

    always_comb begin
      if (mode_nxt) begin
        o_nxt[l*W +: W]           = '0;
        o_nxt[l*W +: CNT_W]       = cnt_v[l];
        o_nxt[l*W + PASS_BIT]     = (cnt_v[l] == '0);
      end else begin
        o_nxt[l*W +: W]           = rx_data[l*W +: W];
      end
    end
  end

  rx_mode_ctl #(.ENTER_RUN(ENTER_RUN), .EXIT_RUN(EXIT_RUN)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (rx_valid),
    .lock     (rx_lock),
    .all_clean(&clean_v),
    .all_miss (&miss_v),
    .mode     (mode),
    .mode_nxt (mode_nxt),
    .enter    (enter)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_o_valid <= 1'b0;
      rx_o_data  <= '0;
    end else begin
      rx_o_valid <= rx_valid;
      if (rx_valid) rx_o_data <= o_nxt;
    end
  end

  assign rx_bist_active = mode;
endmodule

// File: rtl/lane_bist_chk.sv
module lane_bist_chk #(
  parameter int LANES = 2,
  parameter int W     = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_test_en,
  input logic               tx_clk_ok,
  input logic               tx_s_ready,
  input logic               tx_m_valid,
  input logic               tx_m_ready,
  input logic [LANES*W-1:0] tx_m_data,
  input logic               rx_lock,
  input logic               rx_valid,
  input logic               rx_o_valid,
  input logic [LANES*W-1:0] rx_o_data,
  input logic               rx_bist_active
);
  // R2
  tx_test_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_test_en && tx_clk_ok) |-> (tx_s_ready && tx_m_valid));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_test_en && tx_clk_ok && !tx_m_ready) |=>
      (!(tx_test_en && tx_clk_ok) || $stable(tx_m_data)));

  // R4
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_lock |=> !rx_bist_active);

  // R11
  ovalid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_o_valid);

  // R11
  ovalid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !rx_o_valid);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R8
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bist_active && $past(rx_bist_active) && rx_o_valid && $past(rx_o_valid))
        |-> (rx_o_data[l*W +: 8] >= $past(rx_o_data[l*W +: 8])));

    // R7
    field_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bist_active && rx_o_valid) |-> (rx_o_data[l*W + 9 +: W - 9] == '0));
  end
endmodule

bind lane_bist lane_bist_chk #(.LANES(LANES), .W(W)) u_bist_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_test_en    (tx_test_en),
  .tx_clk_ok     (tx_clk_ok),
  .tx_s_ready    (tx_s_ready),
  .tx_m_valid    (tx_m_valid),
  .tx_m_ready    (tx_m_ready),
  .tx_m_data     (tx_m_data),
  .rx_lock       (rx_lock),
  .rx_valid      (rx_valid),
  .rx_o_valid    (rx_o_valid),
  .rx_o_data     (rx_o_data),
  .rx_bist_active(rx_bist_active)
);

// File: tb/sim_lane_bist.sv
`timescale 1ns/1ps
module sim_lane_bist;
  localparam int L = 2;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_test_en = 1'b0, tx_clk_ok = 1'b0;
  logic          tx_s_valid = 1'b0, tx_m_ready = 1'b0;
  logic [L*W-1:0] tx_s_data = '0;
  logic          tx_s_ready, tx_m_valid;
  logic [L*W-1:0] tx_m_data;
  logic          rx_lock = 1'b0, rx_valid = 1'b0;
  logic [L*W-1:0] rx_data = '0;
  logic          rx_o_valid, rx_bist_active;
  logic [L*W-1:0] rx_o_data;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_bist #(.LANES(L), .W(W)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PRBS-7 step of one W-bit word: returns {next state, word}
  function automatic logic [22:0] pstep(logic [6:0] s);
    logic [15:0] w;
    logic nb;
    for (int i = 15; i >= 0; i--) begin
      nb = s[6] ^ s[5];
      w[i] = nb;
      s = {s[5:0], nb};
    end
    return {s, w};
  endfunction

  logic [6:0] ts [L];
  logic [6:0] rs [L];

  function automatic logic [31:0] tx_model();
    logic [31:0] d;
    for (int l = 0; l < L; l++) d[l*W +: W] = pstep(ts[l])[15:0];
    return d;
  endfunction

  task automatic tx_adv();
    for (int l = 0; l < L; l++) ts[l] = pstep(ts[l])[22:16];
  endtask

  function automatic logic [31:0] rx_next();
    logic [31:0] d;
    logic [22:0] r;
    for (int l = 0; l < L; l++) begin
      r = pstep(rs[l]);
      d[l*W +: W] = r[15:0];
      rs[l] = r[22:16];
    end
    return d;
  endfunction

  // drive one receive word at a falling edge, results read at the next one
  task automatic rxw(logic lk, logic [31:0] d);
    rx_valid = 1'b1;
    rx_lock  = lk;
    rx_data  = d;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    ts[0] = 7'd1; ts[1] = 7'd2;
    rs[0] = 7'h5A; rs[1] = 7'h33;
    repeat (3) @(negedge clk);
    chk("R11 reset o_valid", 32'(rx_o_valid), 0);
    chk("R4 reset active", 32'(rx_bist_active), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 pass-through variants
    tx_s_valid = 1'b1; tx_s_data = 32'hA5C3_1234; tx_m_ready = 1'b0;
    #1;
    chk("R1 data", tx_m_data, 32'hA5C3_1234);
    chk("R1 ready", 32'(tx_s_ready), 0);
    tx_test_en = 1'b1; tx_clk_ok = 1'b0; #1;
    chk("R1 no clk", tx_m_data, 32'hA5C3_1234);
    tx_test_en = 1'b0; tx_clk_ok = 1'b1; tx_s_valid = 1'b0; #1;
    chk("R1 no en valid", 32'(tx_m_valid), 0);
    @(negedge clk);

    // R2 pattern
    tx_test_en = 1'b1; tx_m_ready = 1'b1; tx_s_data = 32'hFFFF_0000;
    for (int k = 0; k < 20; k++) begin
      #1;
      chk("R2 prbs word", tx_m_data, tx_model());
      chk("R2 open", {30'd0, tx_s_ready, tx_m_valid}, 32'd3);
      tx_adv();
      @(negedge clk);
    end
    // R3 hold under back-pressure
    tx_m_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R3 hold", tx_m_data, tx_model());
      @(negedge clk);
    end
    tx_m_ready = 1'b1; #1;
    chk("R3 resume", tx_m_data, tx_model());
    @(negedge clk);
    tx_adv(); #1;
    chk("R3 advance", tx_m_data, tx_model());
    tx_test_en = 1'b0; tx_m_ready = 1'b0;

    // R12 zeros never enter
    for (int k = 0; k < 40; k++) rxw(1'b1, 32'd0);
    chk("R12 zeros active", 32'(rx_bist_active), 0);
    chk("R11 raw zeros", rx_o_data, 0);

    // R4 no lock, pattern present
    for (int k = 0; k < 40; k++) begin d = rx_next(); rxw(1'b0, d); end
    chk("R4 unlocked active", 32'(rx_bist_active), 0);
    chk("R11 raw data", rx_o_data, d);
    chk("R11 o_valid", 32'(rx_o_valid), 1);

    // R6 entry on the 32nd clean word
    for (int k = 0; k < 31; k++) rxw(1'b1, rx_next());
    chk("R6 not yet at 31", 32'(rx_bist_active), 0);
    rxw(1'b1, rx_next());
    chk("R6 entered at 32", 32'(rx_bist_active), 1);
    chk("R7 status fields", rx_o_data, 32'h0100_0100);

    // R5 R8 R9 single flip gives 3 errors
    rxw(1'b1, rx_next() ^ 32'h0000_8000);
    chk("R5 three misses", rx_o_data, 32'h0100_0003);
    rxw(1'b1, rx_next());
    chk("R8 no extra", rx_o_data, 32'h0100_0003);
    for (int k = 0; k < 84; k++) rxw(1'b1, rx_next() ^ 32'h0000_8000);
    chk("R8 reach 255", rx_o_data, 32'h0100_00FF);
    rxw(1'b1, rx_next() ^ 32'h0000_8000);
    chk("R8 saturate", rx_o_data, 32'h0100_00FF);
    chk("R9 clean lane pass", 32'(rx_o_data[24]), 1);

    // R10 exit on 64th all-lane mismatch
    for (int k = 0; k < 63; k++) rxw(1'b1, 32'hFFFF_FFFF);
    chk("R10 still active at 63", 32'(rx_bist_active), 1);
    chk("R9 lane1 fails", 32'(rx_o_data[24]), 0);
    rxw(1'b1, 32'hFFFF_FFFF);
    chk("R10 exit at 64", 32'(rx_bist_active), 0);
    chk("R10 raw word", rx_o_data, 32'hFFFF_FFFF);

    // R6 R7 re-entry, counts cleared
    for (int k = 0; k < 32; k++) rxw(1'b1, rx_next());
    chk("R6 reseed not yet", 32'(rx_bist_active), 0);
    rxw(1'b1, rx_next());
    chk("R6 reentered", 32'(rx_bist_active), 1);
    chk("R7 cleared", rx_o_data, 32'h0100_0100);

    // R4 lock loss
    d = rx_next();
    rxw(1'b0, d);
    chk("R4 lock loss", 32'(rx_bist_active), 0);
    chk("R4 raw on loss", rx_o_data, d);

    // R11 valid low
    rx_valid = 1'b0;
    @(negedge clk);
    chk("R11 o_valid low", 32'(rx_o_valid), 0);

    finish_run();
  end
endmodule